// File: doc/BRIEF.md
# Single-Line Interrupt Trigger Controller

This block turns one external interrupt line into a clean, acknowledgeable request for a parent interrupt controller. It is separate from the chip's main interrupt distributor. Software programs a 2-bit trigger mode (active-low level, falling edge, active-high level or rising edge), unmasks or masks the line, and reads and acknowledges a pending flag through a small register interface with registered read data.

The raw line is brought into the clock domain by a synchroniser. A detector evaluates the selected condition on the synchronised sample, and a sticky pending bit records each event. The output request is registered and is high while the line is both pending and enabled. The pending bit keeps recording events while the line is masked, so unmasking later raises the request at once. A compile-time parameter picks one of two address layouts, which differ only in where the enable register sits.

Software brings the block up by writing 0 to the enable register and then 1 to the pending register. This leaves the line masked with nothing pending before a mode is chosen.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset the trigger mode is 0, enable is 0, pending is 0, the request output is 0 and every register reads 0.
- R2: The mode register at byte offset 0x00 holds the trigger mode in bits [1:0]: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. Its other bits ignore writes and read 0.
- R3: A change on the line first seen at clock edge k sets pending at edge k+2. With enable set, the request output rises at edge k+3.
- R4: In the two level modes pending is set on every cycle in which the synchronised line is at the active level. An acknowledge while the line is still active leaves pending set. Once the line is inactive, an acknowledge clears pending.
- R5: In the two edge modes only the selected transition sets pending. After an acknowledge, pending stays clear until the next selected transition. The opposite transition has no effect.
- R6: The pending register at offset 0x04 reads the pending flag in bit 0. Writing 1 to bit 0 clears the flag. Writing 0 has no effect.
- R7: When a new event and a write-one-to-clear of pending fall on the same cycle, pending is left set.
- R8: Bit 0 of the enable register unmasks the line when set and masks it when clear. The enable register is at offset 0x08 when LAYOUT = 0 and at offset 0x34 when LAYOUT = 1. The offset of the other layout is unmapped.
- R9: The request output is a register loaded with pending AND enable. Pending keeps recording events while enable is 0.
- R10: A read returns data one cycle after the read strobe. Unused bits and unmapped offsets read 0. The read data is 0 in any cycle that follows no read.
- R11: With the reset-default mode (active-low level) and the line held low, pending sets without any programming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw asynchronous interrupt line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered request to the parent controller |

## Verification
The bench sweeps all four trigger modes, and for each mode it checks the idle level, the active condition, an acknowledge while the line is still active, and a return to idle. A design that mixed up the mode encoding, or let an edge mode behave like a level mode, would leave pending in the wrong state after the acknowledge. The bench also lines up an edge event with an acknowledge on the same cycle; a design that gave the clear priority would lose that event. It times the request to the exact cycle, so a missing or extra register shows up. Two instances with different layouts share one bus, so an enable decoded at the wrong offset unmasks the wrong instance.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_FALL   = 2'd1,
    TRIG_LVL_HI = 2'd2,
    TRIG_RISE   = 2'd3
  } trig_e;

  localparam int OFF_MODE   = 'h00;
  localparam int OFF_PEND   = 'h04;
  localparam int OFF_EN_LY0 = 'h08;
  localparam int OFF_EN_LY1 = 'h34;

  function automatic int en_offset(input int layout);
    return (layout == 0) ? OFF_EN_LY0 : OFF_EN_LY1;
  endfunction

  // bit 1 of the mode gives the active polarity, bit 0 marks edge modes
  function automatic logic mode_active_high(input trig_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_edge(input trig_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int  STAGES    = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE_LVL}};
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lic_detect.sv
module lic_detect
  import lic_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  s_i,
  input  trig_e mode_i,
  output logic  evt_o
);
  logic s_prev;
  logic act_hi;
  logic lvl_hit;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (rst) s_prev <= IDLE_LVL;
    else     s_prev <= s_i;
  end

  always_comb begin
    act_hi   = mode_active_high(mode_i);
    lvl_hit  = (s_i == act_hi);
    edge_hit = (s_i == act_hi) && (s_prev != act_hi);
    evt_o    = mode_is_edge(mode_i) ? edge_hit : lvl_hit;
  end

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (mode_is_edge(mode_i) && evt_o) |-> (s_i != s_prev)); // R5
endmodule

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int EN_OFF = OFF_EN_LY0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output trig_e             mode_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFF);

  trig_e             mode_q;
  logic              en_q;
  logic              pend_q;
  logic              irq_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              hit_mode, hit_pend, hit_en, ack;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:2];

  always_comb begin
    hit_mode = (addr_i == A_MODE);
    hit_pend = (addr_i == A_PEND);
    hit_en   = (addr_i == A_EN);
    ack      = wr_en_i && hit_pend && wdata_i[0];
    rd_mux   = '0;
    if (hit_mode)      rd_mux[1:0] = mode_q;
    else if (hit_pend) rd_mux[0]   = pend_q;
    else if (hit_en)   rd_mux[0]   = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= TRIG_LVL_LO;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_en_i && hit_mode) mode_q <= trig_e'(wdata_i[1:0]);
      if (wr_en_i && hit_en)   en_q   <= wdata_i[0];
      pend_q  <= (pend_q && !ack) || evt_i;
      irq_q   <= pend_q && en_q;
      rdata_q <= rd_en_i ? rd_mux : '0;
    end
  end

  assign mode_o  = mode_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !evt_i) |=> !pend_q); // R6
  AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> pend_q); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_o); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rdata_o == '0)); // R10
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import lic_pkg::*;
#(
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 32,
  parameter int   LAYOUT      = 0,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int EN_OFF = en_offset(LAYOUT);

  logic  line_s;
  logic  evt;
  trig_e mode;

  lic_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LVL)) u_sync (
    .clk(clk), .rst(rst), .d_i(line_i), .q_o(line_s)
  );

  lic_detect #(.IDLE_LVL(IDLE_LVL)) u_detect (
    .clk(clk), .rst(rst), .s_i(line_s), .mode_i(mode), .evt_o(evt)
  );

  lic_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFF(EN_OFF)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .evt_i(evt), .mode_o(mode),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );
endmodule

// File: tb/line_irq_ctrl_tb.sv
module line_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_MODE = 8'h00, A_PEND = 8'h04, A_EN0 = 8'h08, A_EN1 = 8'h34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_r = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_m, rdata_a;
  logic        irq_m, irq_a;
  logic [31:0] got_m, got_a;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  line_irq_ctrl #(.LAYOUT(0)) u_dut (
    .clk(clk), .rst(rst), .line_i(line_r), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_m), .irq_o(irq_m));

  line_irq_ctrl #(.LAYOUT(1)) u_alt (
    .clk(clk), .rst(rst), .line_i(line_r), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a), .irq_o(irq_a));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; got_m = rdata_m; got_a = rdata_a;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(3);
    // R1 reset state
    chk("R1 irq", {31'b0, irq_m}, 0);
    chk("R1 rdata idle", rdata_m, 0);
    rd_reg(A_MODE); chk("R1 mode", got_m, 0);
    rd_reg(A_PEND); chk("R1 pend", got_m, 0);
    rd_reg(A_EN0);  chk("R1 en", got_m, 0);
    // R11 default active-low level
    line_r = 1'b0; idle(5);
    rd_reg(A_PEND); chk("R11 default low pends", got_m, 1);
    line_r = 1'b1; idle(4);
    wr_reg(A_EN0, 0); wr_reg(A_PEND, 1); idle(1);
    rd_reg(A_PEND); chk("R11 init order clears", got_m, 0);

    // R2/R4/R5 sweep over all modes
    for (int m = 0; m < 4; m++) begin
      logic a;
      a = m[1];
      line_r = ~a; idle(4);
      wr_reg(A_MODE, m); wr_reg(A_PEND, 1); idle(2);
      rd_reg(A_MODE); chk("R2 mode readback", got_m, m);
      rd_reg(A_PEND); chk(m[0] ? "R5 idle no pend" : "R4 idle no pend", got_m, 0);
      line_r = a; idle(5);
      rd_reg(A_PEND); chk(m[0] ? "R5 edge pends" : "R4 level pends", got_m, 1);
      wr_reg(A_PEND, 1); idle(1);
      rd_reg(A_PEND); chk(m[0] ? "R5 ack stays clear" : "R4 ack while active", got_m, m[0] ? 0 : 1);
      line_r = ~a; idle(5);
      wr_reg(A_PEND, 1); idle(3);
      rd_reg(A_PEND); chk(m[0] ? "R5 opposite edge ignored" : "R4 inactive ack clears", got_m, 0);
    end

    // R2 upper bits read zero
    wr_reg(A_MODE, 32'hFFFF_FFFF);
    rd_reg(A_MODE); chk("R2 upper bits zero", got_m, 3);

    // R3 exact latency, rising mode
    line_r = 1'b0; idle(4); wr_reg(A_PEND, 1); wr_reg(A_EN0, 1); idle(2);
    @(negedge clk); line_r = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 irq not before k+3", {31'b0, irq_m}, 0);
    @(negedge clk);
    chk("R3 irq at k+3", {31'b0, irq_m}, 1);

    // R6 write 0 has no effect
    wr_reg(A_PEND, 0);
    rd_reg(A_PEND); chk("R6 write zero keeps pend", got_m, 1);

    // R8 layout decode: alt instance still masked
    chk("R8 alt masked", {31'b0, irq_a}, 0);
    wr_reg(A_EN1, 1); idle(2);
    chk("R8 alt unmasked at 0x34", {31'b0, irq_a}, 1);
    rd_reg(A_EN1); chk("R8 main 0x34 unmapped", got_m, 0); chk("R8 alt en read", got_a, 1);
    rd_reg(A_EN0); chk("R8 main en read", got_m, 1); chk("R8 alt 0x08 unmapped", got_a, 0);
    rd_reg(8'h0C); chk("R10 unmapped reads zero", got_m, 0);

    // R9 masked latching
    wr_reg(A_EN0, 0); idle(1);
    chk("R9 masked irq low", {31'b0, irq_m}, 0);
    line_r = 1'b0; idle(4); wr_reg(A_PEND, 1); idle(1);
    line_r = 1'b1; idle(5);
    rd_reg(A_PEND); chk("R9 pend latched while masked", got_m, 1);
    chk("R9 irq still low", {31'b0, irq_m}, 0);
    wr_reg(A_EN0, 1); idle(1);
    chk("R9 unmask raises irq", {31'b0, irq_m}, 1);

    // R7 event and clear on the same cycle, pend already set
    line_r = 1'b0; idle(4);
    @(negedge clk); line_r = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = A_PEND; wdata = 1;
    @(negedge clk); wr = 1'b0; wdata = 0;
    rd_reg(A_PEND); chk("R7 event wins over clear", got_m, 1);
    wr_reg(A_PEND, 1); idle(1);
    rd_reg(A_PEND); chk("R5 plain ack clears", got_m, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule